// File: doc/BRIEF.md
# I2C Master Byte Queue

This block is a small byte queue placed between a byte-wide host register port and an I2C master engine. The host adds bytes with a push strobe and removes them with a pop strobe. The byte at the head of the queue is always visible on the read data output. If the queue is empty, that output shows all ones. The engine has its own path into the storage. It can write any slot directly while a receive is running. When the receive ends, it can set the fill level to the number of bytes it received. It can also read any slot on a separate port while it transmits.

Two status flags report the queue state: one for "holds data" and one for "full". Both are registers. They change only when a push, a pop, a flush or an engine completion moves the fill level across the relevant boundary. They are never decoded from the level. The fill level is kept as a count from 0 to DEPTH, so level minus one is the index of the last valid slot. A flush command empties the queue, clears every slot to zero and drops both flags.

Top module: `i2c_mdata_buffer`

## Requirements
- R1: After reset the fill level is 0, both flags are low, every slot holds zero and the read data output is all ones.
- R2: While the fill level is 0, the read data output is all ones, and a pop changes neither the level, the flags nor any slot.
- R3: A pop with level > 0 presents slot 0 on the read data output before the edge. At the edge it moves every slot k+1 into slot k and lowers the level by one. The top slot keeps its old value.
- R4: A push with level < DEPTH stores the byte in slot `level` and raises the level by one. A push while the level equals DEPTH is dropped and leaves the level and every slot unchanged.
- R5: The holds-data flag rises when a push takes the level from 0 to 1. It falls when a pop takes the level from 1 to 0.
- R6: The full flag rises when a push takes the level to DEPTH. It falls when a pop is taken at level DEPTH.
- R7: A flush sets the level to 0, zeroes every slot and clears both flags. It wins over every other input in the same cycle.
- R8: An engine slot write stores its byte in the slot named by its index and leaves the level and the flags unchanged. While the engine write or the engine completion is active, host push and pop are ignored.
- R9: An engine completion sets the level to the received count, clamped to DEPTH. It sets the holds-data flag to (level > 0) and the full flag to (level == DEPTH).
- R10: A push and a pop in the same cycle act as a pop followed by a push. At level DEPTH both take effect, and the level and the full flag stay as they were.
- R11: The engine read port returns, in the same cycle, the slot selected by its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_push | input | 1 | Host push strobe |
| host_push_data | input | DATA_W | Byte to push |
| host_pop | input | 1 | Host pop strobe |
| host_rd_data | output | DATA_W | Head byte, all ones when empty |
| flush | input | 1 | Empty and clear the queue |
| eng_ld_en | input | 1 | Engine slot write strobe |
| eng_ld_idx | input | IDX_W | Engine slot write index |
| eng_ld_data | input | DATA_W | Engine slot write byte |
| eng_done | input | 1 | Engine receive completion strobe |
| eng_done_count | input | CNT_W | Bytes received |
| eng_rd_idx | input | IDX_W | Engine read slot index |
| eng_rd_data | output | DATA_W | Engine read slot byte |
| fill_level | output | CNT_W | Number of valid bytes |
| flag_has_data | output | 1 | Holds-data flag |
| flag_full | output | 1 | Full flag |

## Verification
The assertions assume that the engine never raises its completion with a count that conflicts with its own slot writes. They also assume that no input is unknown outside reset. Under these assumptions, each flag always matches the boundary its level implies. The random stimulus draws every strobe independently, so flush, engine and host operations often collide in the same cycle. Engine completions are kept rare, so most flag changes come from push and pop crossings, and completion counts above DEPTH are drawn on purpose to exercise the clamp.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
   typedef struct packed {
      logic has_data;
      logic full;
   } mdb_flags_t;

   typedef enum logic [1:0] {
      HOST_IDLE = 2'b00,
      HOST_POP  = 2'b01,
      HOST_PUSH = 2'b10,
      HOST_BOTH = 2'b11
   } mdb_host_op_e;
endpackage

// File: rtl/mdb_occupancy.sv
module mdb_occupancy
   import mdb_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_push,
   input  logic             host_pop,
   input  logic             flush,
   input  logic             eng_hold,
   input  logic             eng_done,
   input  logic [CNT_W-1:0] eng_count,
   output logic [CNT_W-1:0] level,
   output mdb_flags_t       flags,
   output logic             do_pop,
   output logic             do_push,
   output logic [CNT_W-1:0] push_slot
);
   localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LVL_TOP = CNT_W'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $error("mdb_occupancy: DEPTH must be at least 2");
      if ((1 << CNT_W) <= DEPTH) $error("mdb_occupancy: CNT_W too narrow");
   end

   logic [CNT_W-1:0] level_q, level_d, after_pop, clamp_cnt;
   mdb_flags_t       flags_q, flags_d;
   mdb_host_op_e     op;

   assign op        = mdb_host_op_e'({host_push, host_pop});
   assign do_pop    = !flush && !eng_hold && (op == HOST_POP || op == HOST_BOTH)
                      && (level_q != '0);
   assign after_pop = do_pop ? level_q - CNT_W'(1) : level_q;
   assign do_push   = !flush && !eng_hold && (op == HOST_PUSH || op == HOST_BOTH)
                      && (after_pop != LVL_MAX);
   assign push_slot = after_pop;
   assign clamp_cnt = (eng_count > LVL_MAX) ? LVL_MAX : eng_count;

   always_comb begin
      level_d = level_q;
      flags_d = flags_q;
      if (flush) begin
         level_d = '0;
         flags_d = '0;
      end else if (eng_done) begin
         level_d          = clamp_cnt;
         flags_d.has_data = (clamp_cnt != '0);
         flags_d.full     = (clamp_cnt == LVL_MAX);
      end else if (!eng_hold) begin
         if (do_pop) begin
            if (level_q == LVL_MAX) flags_d.full = 1'b0;
            if (level_q == CNT_W'(1)) flags_d.has_data = 1'b0;
         end
         level_d = after_pop;
         if (do_push) begin
            level_d = after_pop + CNT_W'(1);
            if (after_pop == '0) flags_d.has_data = 1'b1;
            if (after_pop == LVL_TOP) flags_d.full = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         flags_q <= '0;
      end else begin
         level_q <= level_d;
         flags_q <= flags_d;
      end
   end

   assign level = level_q;
   assign flags = flags_q;

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_MAX);
   a_r5_has_data_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.has_data == (level_q != '0));
   a_r6_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      flags_q.full == (level_q == LVL_MAX));
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level_q == '0) && !flags_q.has_data && !flags_q.full);
   a_r9_done_level: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !flush && eng_count <= LVL_MAX) |=> level_q == $past(eng_count));
   a_r8_hold_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_hold && !eng_done && !flush) |=> $stable(level_q));
   a_r10_full_both_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (host_push && host_pop && !eng_hold && !flush && level_q == LVL_MAX)
      |=> level_q == LVL_MAX && flags_q.full);
endmodule

// File: rtl/mdb_storage.sv
module mdb_storage #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        shift,
   input  logic                        push_en,
   input  logic [CNT_W-1:0]            push_slot,
   input  logic [DATA_W-1:0]           push_data,
   input  logic                        ld_en,
   input  logic [IDX_W-1:0]            ld_idx,
   input  logic [DATA_W-1:0]           ld_data,
   output logic [DEPTH-1:0][DATA_W-1:0] slots
);
   initial begin
      if (DATA_W < 1) $error("mdb_storage: DATA_W must be positive");
   end

   logic [DEPTH-1:0][DATA_W-1:0] slot_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DATA_W-1:0] moved, next;
      if (i < DEPTH - 1) begin : g_shift
         assign moved = shift ? slot_q[i+1] : slot_q[i];
      end else begin : g_top
         assign moved = slot_q[i];
      end

      always_comb begin
         next = moved;
         if (flush) next = '0;
         else if (ld_en && ld_idx == IDX_W'(i)) next = ld_data;
         else if (push_en && push_slot == CNT_W'(i)) next = push_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) slot_q[i] <= '0;
         else        slot_q[i] <= next;
      end
   end

   assign slots = slot_q;

   a_r7_flush_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> slot_q == '0);
   a_r8_no_host_with_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> !shift && !push_en);
endmodule

// File: rtl/i2c_mdata_buffer.sv
module i2c_mdata_buffer
   import mdb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1),
   parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_push,
   input  logic [DATA_W-1:0] host_push_data,
   input  logic              host_pop,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              flush,
   input  logic              eng_ld_en,
   input  logic [IDX_W-1:0]  eng_ld_idx,
   input  logic [DATA_W-1:0] eng_ld_data,
   input  logic              eng_done,
   input  logic [CNT_W-1:0]  eng_done_count,
   input  logic [IDX_W-1:0]  eng_rd_idx,
   output logic [DATA_W-1:0] eng_rd_data,
   output logic [CNT_W-1:0]  fill_level,
   output logic              flag_has_data,
   output logic              flag_full
);
   logic                         do_pop, do_push, eng_hold;
   logic [CNT_W-1:0]             push_slot, level;
   mdb_flags_t                   flags;
   logic [DEPTH-1:0][DATA_W-1:0] slots;

   assign eng_hold = eng_ld_en || eng_done;

   mdb_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_push (host_push),
      .host_pop  (host_pop),
      .flush     (flush),
      .eng_hold  (eng_hold),
      .eng_done  (eng_done),
      .eng_count (eng_done_count),
      .level     (level),
      .flags     (flags),
      .do_pop    (do_pop),
      .do_push   (do_push),
      .push_slot (push_slot)
   );

   mdb_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .shift     (do_pop),
      .push_en   (do_push),
      .push_slot (push_slot),
      .push_data (host_push_data),
      .ld_en     (eng_ld_en && !flush),
      .ld_idx    (eng_ld_idx),
      .ld_data   (eng_ld_data),
      .slots     (slots)
   );

   assign host_rd_data  = (level == '0) ? '1 : slots[0];
   assign eng_rd_data   = (int'(eng_rd_idx) < DEPTH) ? slots[eng_rd_idx] : '0;
   assign fill_level    = level;
   assign flag_has_data = flags.has_data;
   assign flag_full     = flags.full;

   a_r2_empty_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0) |-> host_rd_data == '1);
   a_r2_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0 && host_pop && !host_push && !flush && !eng_hold)
      |=> fill_level == '0 && !flag_has_data);
   a_r3_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level != '0 && host_pop && !host_push && !flush && !eng_hold)
      |=> fill_level == $past(fill_level) - CNT_W'(1));
endmodule

// File: tb/i2c_mdata_buffer_tb.sv
module i2c_mdata_buffer_tb;
   localparam int DEPTH = 4;
   localparam int DW    = 8;
   localparam int CW    = 3;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_push = 0, host_pop = 0, flush = 0;
   logic [DW-1:0] host_push_data = '0, eng_ld_data = '0;
   logic          eng_ld_en = 0, eng_done = 0;
   logic [IW-1:0] eng_ld_idx = '0, eng_rd_idx = '0;
   logic [CW-1:0] eng_done_count = '0;
   logic [DW-1:0] host_rd_data, eng_rd_data;
   logic [CW-1:0] fill_level;
   logic          flag_has_data, flag_full;

   int vectors = 0, fails = 0;

   logic [DW-1:0] m_slot [DEPTH];
   int            m_lvl;
   logic          m_hd, m_full;

   always #10 clk = ~clk;

   i2c_mdata_buffer u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_push(host_push), .host_push_data(host_push_data),
      .host_pop(host_pop), .host_rd_data(host_rd_data), .flush(flush),
      .eng_ld_en(eng_ld_en), .eng_ld_idx(eng_ld_idx), .eng_ld_data(eng_ld_data),
      .eng_done(eng_done), .eng_done_count(eng_done_count),
      .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
      .fill_level(fill_level), .flag_has_data(flag_has_data), .flag_full(flag_full)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_head();
      return (m_lvl == 0) ? 8'hFF : m_slot[0];
   endfunction

   task automatic check_all(input string tag);
      chk({tag, " R4 level"}, int'(fill_level), m_lvl);
      chk({tag, " R5 has_data"}, int'(flag_has_data), int'(m_hd));
      chk({tag, " R6 full"}, int'(flag_full), int'(m_full));
      chk({tag, (m_lvl == 0) ? " R2 head" : " R3 head"}, int'(host_rd_data), int'(exp_head()));
      chk({tag, " R11 eng_rd"}, int'(eng_rd_data), int'(m_slot[eng_rd_idx]));
   endtask

   function automatic void model_step();
      int c;
      if (flush) begin
         for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
         m_lvl = 0; m_hd = 0; m_full = 0;
      end else if (eng_ld_en || eng_done) begin
         if (eng_ld_en) m_slot[eng_ld_idx] = eng_ld_data;
         if (eng_done) begin
            c = int'(eng_done_count);
            m_lvl = (c > DEPTH) ? DEPTH : c;
            m_hd = (m_lvl > 0); m_full = (m_lvl == DEPTH);
         end
      end else begin
         if (host_pop && m_lvl > 0) begin
            if (m_lvl == DEPTH) m_full = 0;
            if (m_lvl == 1) m_hd = 0;
            for (int i = 0; i < DEPTH - 1; i++) m_slot[i] = m_slot[i+1];
            m_lvl--;
         end
         if (host_push && m_lvl < DEPTH) begin
            m_slot[m_lvl] = host_push_data;
            m_lvl++;
            if (m_lvl == 1) m_hd = 1;
            if (m_lvl == DEPTH) m_full = 1;
         end
      end
   endfunction

   task automatic idle();
      host_push = 0; host_pop = 0; flush = 0; eng_ld_en = 0; eng_done = 0;
   endtask

   task automatic cycle(input string tag);
      #1;
      check_all(tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      idle();
   endtask

   task automatic push(input logic [DW-1:0] d, input string tag);
      host_push = 1; host_push_data = d; cycle(tag);
   endtask

   task automatic pop(input string tag);
      host_pop = 1; cycle(tag);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd7391));
      for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
      m_lvl = 0; m_hd = 0; m_full = 0;
      repeat (3) @(negedge clk);
      eng_rd_idx = 2'd3;
      #1 check_all("R1 reset");
      rst_n = 1;
      @(negedge clk);

      pop("R2 pop empty");
      push(8'h11, "R5 first push");
      push(8'h22, "R4 push");
      push(8'h33, "R4 push");
      push(8'h44, "R6 fill");
      push(8'h99, "R4 push when full dropped");
      host_push = 1; host_pop = 1; host_push_data = 8'h55;
      cycle("R10 both at full");
      pop("R3 pop from full");
      pop("R3 pop");
      pop("R3 pop");
      pop("R5 last pop");
      host_push = 1; host_pop = 1; host_push_data = 8'h66;
      cycle("R10 both at empty");
      cycle("R10 after");
      eng_ld_en = 1; eng_ld_idx = 2'd2; eng_ld_data = 8'hA5; host_push = 1; host_pop = 1;
      cycle("R8 load blocks host");
      eng_done = 1; eng_done_count = 3'd7; host_pop = 1;
      cycle("R9 done clamp");
      flush = 1; host_push = 1; eng_done = 1; eng_done_count = 3'd2;
      cycle("R7 flush wins");
      cycle("R7 after flush");

      for (int n = 0; n < 3000; n++) begin
         host_push      = ($urandom % 2) == 0;
         host_pop       = ($urandom % 3) == 0;
         host_push_data = DW'($urandom);
         flush          = ($urandom % 40) == 0;
         eng_ld_en      = ($urandom % 12) == 0;
         eng_ld_idx     = IW'($urandom);
         eng_ld_data    = DW'($urandom);
         eng_done       = ($urandom % 30) == 0;
         eng_done_count = CW'($urandom);
         eng_rd_idx     = IW'($urandom);
         cycle("random");
      end
      #1 check_all("final");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule